// File: doc/BRIEF.md
# Loss-of-Signal Output Edge Blanking

This block sits between a loss-of-signal comparator and the pin or register that reports signal loss. It brings the raw comparator flag into the system clock domain and passes it on. After a transition it can also hold the reported flag still for a programmable time, so that input chatter is not reported. That chatter is typical right after the signal disappears or while it comes back.

Rising transitions (signal lost) and falling transitions (signal restored) are treated separately. Each direction has its own enable and its own 7-bit duration code. The duration counts in coarse steps of one time base tick. The tick comes from a prescaler on the system clock. With the default divide of 6400 at 200 MHz, one step is 32 µs, and the 7-bit code spans about 32 µs to about 4 ms.

All pins are plain level-sensitive control and status signals. There is no data stream, so no valid/ready handshake applies and nothing is ever back-pressured. The configuration inputs are expected to come straight from configuration registers.

Top module: `los_mask_top`

## Requirements
- R1: `los_raw` passes through a two-flop synchronizer. With blanking disabled, a change on `los_raw` appears on `los_out` at the third rising clock edge after the change.
- R2: When `los_out` rises and `rise_mask_en` is 1, `los_out` holds for exactly (rise_mask_code + 1) × TICK_DIV cycles. Its earliest next change is that many cycles after the rise. The code is a 7-bit unsigned number.
- R3: When `los_out` falls and `fall_mask_en` is 1, `los_out` holds for exactly (fall_mask_code + 1) × TICK_DIV cycles. The code is a 7-bit unsigned number.
- R4: An edge direction whose enable is 0 starts no blanking. Changes in that direction pass with the R1 latency, including a pulse only one cycle wide.
- R5: While blanking is active, changes of the synchronized input are ignored. A glitch that has settled back before the interval ends leaves `los_out` unchanged.
- R6: At the clock edge that ends an interval, `los_out` takes the current synchronized input. If that is a transition whose direction is enabled, a new interval starts at the same edge.
- R7: Enable and code are sampled only at the edge that starts an interval. Changing them during an interval affects only later edges.
- R8: Asynchronous active-low reset `rst_n` forces `los_out` to 0, empties the synchronizer and cancels any active interval.
- R9: One step is TICK_DIV clock cycles. The default is 6400, which is 32 µs at 200 MHz. The prescaler restarts at each interval start, so every interval is an exact multiple of TICK_DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| los_raw | input | 1 | Raw loss-of-signal flag from the comparator, asynchronous |
| rise_mask_en | input | 1 | Enable blanking after a rising output edge |
| rise_mask_code | input | 7 | Rising-edge blanking length, (code+1) steps |
| fall_mask_en | input | 1 | Enable blanking after a falling output edge |
| fall_mask_code | input | 7 | Falling-edge blanking length, (code+1) steps |
| los_out | output | 1 | Synchronized, blanked loss-of-signal flag |

## Verification
A pass-through change is due at the third rising edge after the input moves. That is two synchronizer flops plus the output register. A blanked edge at cycle E makes the next possible change due at exactly E + (code+1)·TICK_DIV, with no added release cycle. The bench counts clock edges and drives inputs on falling edges. For every stimulus it queues the cycle index and value of each output transition it predicts. A monitor samples `los_out` on falling edges and matches each observed transition against the head of that queue. An early, late, missing or extra transition is therefore caught at its exact cycle.

// File: rtl/los_mask_pkg.sv
`timescale 1ns/1ps
package los_mask_pkg;
  parameter int DEF_CODE_W   = 7;
  parameter int DEF_TICK_DIV = 6400;  // 32 us at 200 MHz

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2
  } edge_kind_e;
endpackage

// File: rtl/los_sync.sv
`timescale 1ns/1ps
module los_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/los_tick_gen.sv
`timescale 1ns/1ps
module los_tick_gen #(
  parameter int TICK_DIV = 6400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  generate
    if (TICK_DIV < 2) begin : g_every
      assign tick = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (clr)         cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end

      assign tick = (cnt == LAST);

      // R9: a restart never yields a tick on the following cycle
      p_fresh_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tick);
      // R9: ticks are never back to back
      p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/los_hold_ctrl.sv
`timescale 1ns/1ps
module los_hold_ctrl
  import los_mask_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              los_s,
  input  logic              tick,
  input  logic              rise_en,
  input  logic [CODE_W-1:0] rise_code,
  input  logic              fall_en,
  input  logic [CODE_W-1:0] fall_code,
  output logic              los_out,
  output logic              restart
);
  localparam int RW = CODE_W + 1;

  logic              hold;
  logic [RW-1:0]     rem;
  logic              rel_now;
  logic              open_now;
  logic              start;
  edge_kind_e        kind;
  logic [CODE_W-1:0] sel_code;

  always_comb begin
    rel_now  = hold && tick && (rem == RW'(1));
    open_now = !hold || rel_now;
    kind     = EDGE_NONE;
    if (open_now && (los_s != los_out))
      kind = los_s ? EDGE_RISE : EDGE_FALL;
    start    = ((kind == EDGE_RISE) && rise_en) || ((kind == EDGE_FALL) && fall_en);
    sel_code = (kind == EDGE_RISE) ? rise_code : fall_code;
  end

  assign restart = start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_out <= 1'b0;
      hold    <= 1'b0;
      rem     <= '0;
    end else begin
      if (kind != EDGE_NONE) los_out <= los_s;
      if (start) begin
        hold <= 1'b1;
        rem  <= RW'({1'b0, sel_code}) + RW'(1);
      end else if (rel_now) begin
        hold <= 1'b0;
      end else if (hold && tick) begin
        rem  <= rem - 1'b1;
      end
    end
  end

  // R5: output frozen while an interval runs
  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !rel_now) |=> $stable(los_out));
  // R4: disabled direction passes without starting an interval
  p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && (los_s != los_out) && !(los_s ? rise_en : fall_en))
      |=> (los_out == $past(los_s)) && !hold);
  // R2: enabled rise loads its own length
  p_rise_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && los_s && !los_out && rise_en)
      |=> hold && (rem == RW'({1'b0, $past(rise_code)}) + RW'(1)));
  // R3: enabled fall loads its own length
  p_fall_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !los_s && los_out && fall_en)
      |=> hold && (rem == RW'({1'b0, $past(fall_code)}) + RW'(1)));
  // R6: end of interval adopts the synchronized input
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rel_now |=> (los_out == $past(los_s)));
  // R7: count only moves on steps, regardless of configuration
  p_count_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !tick) |=> hold && $stable(rem));
endmodule

// File: rtl/los_mask_top.sv
`timescale 1ns/1ps
module los_mask_top #(
  parameter int TICK_DIV    = los_mask_pkg::DEF_TICK_DIV,
  parameter int CODE_W      = los_mask_pkg::DEF_CODE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              los_raw,
  input  logic              rise_mask_en,
  input  logic [CODE_W-1:0] rise_mask_code,
  input  logic              fall_mask_en,
  input  logic [CODE_W-1:0] fall_mask_code,
  output logic              los_out
);
  logic los_s;
  logic step_tick;
  logic step_clr;

  los_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (los_raw),
    .q_sync  (los_s)
  );

  los_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (step_clr),
    .tick  (step_tick)
  );

  los_hold_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .los_s     (los_s),
    .tick      (step_tick),
    .rise_en   (rise_mask_en),
    .rise_code (rise_mask_code),
    .fall_en   (fall_mask_en),
    .fall_code (fall_mask_code),
    .los_out   (los_out),
    .restart   (step_clr)
  );
endmodule

// File: tb/los_mask_top_tb.sv
`timescale 1ns/1ps
module los_mask_top_tb;
  localparam int DIV = 4;
  localparam int CW  = 7;

  typedef struct {
    int    cyc;
    bit    val;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic los_raw;
  logic rise_en, fall_en;
  logic [CW-1:0] rise_code, fall_code;
  logic los_out;

  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   prev = 1'b0;
  bit   done = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  los_mask_top #(.TICK_DIV(DIV), .CODE_W(CW)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .los_raw        (los_raw),
    .rise_mask_en   (rise_en),
    .rise_mask_code (rise_code),
    .fall_mask_en   (fall_en),
    .fall_mask_code (fall_code),
    .los_out        (los_out)
  );

  task automatic expect_at(int c, bit v, string r);
    exp_t e;
    e.cyc = c; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic check(bit ok, string r, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic go(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: pops predicted transitions as the output moves
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev = los_out;
      end else if (los_out !== prev) begin
        prev = los_out;
        if (q.size() == 0) begin
          check(1'b0, "R5 unexpected toggle at cycle", cyc, -1);
        end else begin
          e = q.pop_front();
          total++;
          if (cyc != e.cyc || los_out != e.val) begin
            bad++;
            $display("FAIL %s actual=cyc%0d/val%0d expected=cyc%0d/val%0d",
                     e.req, cyc, los_out, e.cyc, e.val);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, e, r;
    rst_n = 1'b0; los_raw = 1'b0;
    rise_en = 1'b0; fall_en = 1'b0; rise_code = '0; fall_code = '0;
    repeat (3) @(negedge clk);
    check(los_out == 1'b0, "R8 reset value", los_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R4: pass-through, including a one-cycle pulse
    c = cyc; los_raw = 1'b1; expect_at(c + 3, 1'b1, "R1 rise latency");
    go(c + 6);
    c = cyc; los_raw = 1'b0; expect_at(c + 3, 1'b0, "R1 fall latency");
    go(c + 6);
    c = cyc; los_raw = 1'b1; expect_at(c + 3, 1'b1, "R4 pulse rise");
    go(c + 1); los_raw = 1'b0; expect_at(c + 4, 1'b0, "R4 pulse fall");
    go(c + 8);

    // R2 / R5: rise blanking of 3 steps swallows a glitch
    rise_en = 1'b1; rise_code = 7'd2;
    c = cyc; los_raw = 1'b1; e = c + 3; expect_at(e, 1'b1, "R2 blanked rise");
    go(e + 1); los_raw = 1'b0;
    go(e + 8); los_raw = 1'b1;
    go(e + 11);
    check(los_out == 1'b1, "R5 frozen during interval", los_out, 1);
    go(e + 14); los_raw = 1'b0; expect_at(e + 17, 1'b0, "R5 fall after interval");
    go(e + 22);

    // R3 / R6: back-to-back intervals chained at release edges
    rise_code = 7'd0; fall_en = 1'b1; fall_code = 7'd1;
    c = cyc; los_raw = 1'b1; e = c + 3;
    expect_at(e,      1'b1, "R2 rise with 1 step");
    expect_at(e + 4,  1'b0, "R6 fall at release");
    expect_at(e + 12, 1'b1, "R3 fall interval 2 steps");
    go(e); los_raw = 1'b0;
    go(e + 5); los_raw = 1'b1;
    go(e + 20);
    check(los_out == 1'b1, "R6 settled value", los_out, 1);

    // R7: code changed mid-interval applies to the next edge only
    fall_en = 1'b0; rise_code = 7'd1;
    c = cyc; los_raw = 1'b0; expect_at(c + 3, 1'b0, "R4 unblanked fall");
    go(c + 6); los_raw = 1'b1; e = c + 9; expect_at(e, 1'b1, "R2 rise 2 steps");
    go(e + 1); rise_code = 7'd5;
    go(e + 2); los_raw = 1'b0; expect_at(e + 8, 1'b0, "R7 old length kept");
    go(e + 9); los_raw = 1'b1; expect_at(e + 12, 1'b1, "R7 next rise");
    go(e + 13); los_raw = 1'b0; expect_at(e + 36, 1'b0, "R7 new length used");
    go(e + 40);

    // R8: reset cancels an active interval
    rise_code = 7'd3;
    c = cyc; los_raw = 1'b1; e = c + 3; expect_at(e, 1'b1, "R2 rise before reset");
    go(e + 2); rst_n = 1'b0;
    go(e + 3);
    check(los_out == 1'b0, "R8 reset mid-interval", los_out, 0);
    go(e + 5); rst_n = 1'b1; r = cyc;
    expect_at(r + 3, 1'b1, "R8 resync after reset");
    go(r + 4); los_raw = 1'b0; expect_at(r + 19, 1'b0, "R9 4-step interval");
    go(r + 25);

    while (q.size() > 0) begin
      exp_t m;
      m = q.pop_front();
      check(1'b0, m.req, -1, m.cyc);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule